// File: doc/BRIEF.md
# Indexed Chipset Configuration Register File

This block holds the configuration state of a legacy-style system chipset. Software reaches it over a small 8-bit I/O bus through two ports. A write to the index port (0xF2) chooses one of 256 byte-wide registers. Accesses to the data port (0xF3) then read or write that register. Each register has its own write mask, so bits that are not implemented always read back as zero.

Several outputs are decoded from the stored values:
- a level that enables the external cache;
- a level that enables the internal cache;
- a single-cycle strobe that tells the CPU side to recompute its memory wait states.

A purely combinational shadow decoder sits beside the register file. It looks at a 20-bit memory address and a read/write flag. It then reports whether the access is served by internal DRAM, is sent to the external bus, or is a write that is silently dropped because shadow memory is write-protected.

Top module: `cfgBlock`

## Requirements
- R1: After reset the index and all 256 registers read as zero. The external-cache enable is 0 and the internal-cache enable is 1. Every access in 0xC0000–0xFFFFF goes to the external bus.
- R2: A write to port 0xF2 loads the index. A read of port 0xF2 returns the current index.
- R3: A write to port 0xF3 stores the byte into the register the index selects. A read of port 0xF3 returns that register. Indices without a mask keep all 8 bits.
- R4: Stored values are ANDed with a per-register mask: 0x01→0xD3, 0x02→0x7F, 0x03→0x1F, 0x05→0xF3, 0x06 and 0x07→0x1F, 0x08→0x0F, 0x09→0x03, 0x12→0xBB, 0x18→0x77, 0x19→0xFB, 0x1B→0xEF.
- R5: Bits 0..4 of register 0x02 enable five shadow windows:
  - bit 0: 0xC0000–0xC7FFF
  - bit 1: 0xC8000–0xCFFFF
  - bit 2: 0xD0000–0xDFFFF
  - bit 3: 0xE0000–0xEFFFF
  - bit 4: 0xF0000–0xFFFFF

  A read inside an enabled window asserts hitInternal only.
- R6: A write inside an enabled window asserts hitInternal when bit 5 of register 0x02 is 0, and writeDrop when it is 1.
- R7: Any access inside a disabled window asserts toExternal only.
- R8: Addresses below 0xC0000 always assert hitInternal only, whatever register 0x02 holds. Exactly one of the three decoder outputs is high for every access.
- R9: extCacheEn equals bit 0 of register 0x04.
- R10: intCacheEn equals the inverse of bit 6 of register 0x1A.
- R11: A data-port write to index 0x01, 0x04 or 0x1A raises waitUpd for exactly the one cycle after the write edge. Writes to any other index do not raise it.
- R12: A bus cycle with ioCs low, or with an address other than 0xF2/0xF3, changes no state. Reads in such cycles return 0x00, as do cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioCs | input | 1 | I/O chip select |
| ioWr | input | 1 | I/O write strobe, one cycle |
| ioRd | input | 1 | I/O read strobe |
| ioAddr | input | 16 | I/O port address |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data, combinational while ioRd is high |
| extCacheEn | output | 1 | External cache enable |
| intCacheEn | output | 1 | Internal cache enable |
| waitUpd | output | 1 | One-cycle wait-state update strobe |
| memAddr | input | 20 | Memory address presented to the shadow decoder |
| memWrite | input | 1 | 1 = write access, 0 = read access |
| hitInternal | output | 1 | Access served by internal DRAM |
| toExternal | output | 1 | Access forwarded to the external bus |
| writeDrop | output | 1 | Write discarded (write-protected shadow) |

## Verification
Random index/data pairs are written and read back; about half of them target the low 32 indices, where the masks live. Comparing the read-back against a model of the masks separates a wrong mask from a wrong index decode.

The shadow decoder is probed in two ways:
- Random addresses are drawn across the whole 1 MB under random contents of register 0x02, so window boundaries, the protect bit and the read/write flag are all exercised together.
- Directed probes sit on the first and last byte of each window, which catches off-by-one range errors.

Writes to the three strobe-triggering indices are mixed with writes to their neighbours, so a pulse on the wrong index is seen. Deselected and wrong-port cycles are followed by read-back to confirm that nothing changed.

// File: rtl/cfgPkg.sv
package cfgPkg;
  typedef struct packed {
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } ioStrobes_t;

  function automatic logic [7:0] wrMask(input logic [7:0] idx);
    case (idx)
      8'h01: wrMask = 8'hD3;
      8'h02: wrMask = 8'h7F;
      8'h03: wrMask = 8'h1F;
      8'h05: wrMask = 8'hF3;
      8'h06, 8'h07: wrMask = 8'h1F;
      8'h08: wrMask = 8'h0F;
      8'h09: wrMask = 8'h03;
      8'h12: wrMask = 8'hBB;
      8'h18: wrMask = 8'h77;
      8'h19: wrMask = 8'hFB;
      8'h1B: wrMask = 8'hEF;
      default: wrMask = 8'hFF;
    endcase
  endfunction

  function automatic logic isWaitIdx(input logic [7:0] idx);
    isWaitIdx = (idx == 8'h01) || (idx == 8'h04) || (idx == 8'h1A);
  endfunction
endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import cfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 'hF2,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'hF3
) (
  input  logic              ioCs,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  output ioStrobes_t        stb
);
  logic selIdx, selData;
  assign selIdx  = ioCs && (ioAddr == IDX_PORT);
  assign selData = ioCs && (ioAddr == DATA_PORT);

  always_comb begin
    stb.idxWr  = selIdx && ioWr;
    stb.dataWr = selData && ioWr;
    stb.idxRd  = selIdx && ioRd;
    stb.dataRd = selData && ioRd;
  end
endmodule

// File: rtl/cfgData.sv
module cfgData
  import cfgPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 256,
  parameter int NUM_WIN = 5,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              extCacheEn,
  output logic              intCacheEn,
  output logic              waitUpd,
  output logic [NUM_WIN-1:0] shadowEn,
  output logic              wrProt
);
  logic [IDX_W-1:0]  index;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      index   <= '0;
      waitUpd <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      waitUpd <= stb.dataWr && isWaitIdx(8'(index));
      if (stb.idxWr) index <= wdata[IDX_W-1:0];
      if (stb.dataWr) regFile[index] <= wdata & wrMask(8'(index));
    end
  end

  always_comb begin
    if (stb.idxRd)       rdata = DATA_W'(index);
    else if (stb.dataRd) rdata = regFile[index];
    else                 rdata = '0;
  end

  assign extCacheEn = regFile[8'h04][0];
  assign intCacheEn = ~regFile[8'h1A][6];
  assign shadowEn   = regFile[8'h02][NUM_WIN-1:0];
  assign wrProt     = regFile[8'h02][5];
endmodule

// File: rtl/shadowDecode.sv
module shadowDecode #(
  parameter int MEM_AW = 20,
  parameter int NUM_WIN = 5
) (
  input  logic [MEM_AW-1:0]  memAddr,
  input  logic               memWrite,
  input  logic [NUM_WIN-1:0] shadowEn,
  input  logic               wrProt,
  output logic               hitInternal,
  output logic               toExternal,
  output logic               writeDrop
);
  localparam int SMALL_SZ = 'h8000;
  localparam int LARGE_SZ = 'h10000;
  localparam int BASE0    = 'hC0000;

  logic [NUM_WIN-1:0] inWin;

  for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
    localparam int BASE = (w <= 1) ? BASE0 + w * SMALL_SZ : BASE0 + 2 * SMALL_SZ + (w - 2) * LARGE_SZ;
    localparam int SIZE = (w <= 1) ? SMALL_SZ : LARGE_SZ;
    assign inWin[w] = (int'(memAddr) >= BASE) && (int'(memAddr) < BASE + SIZE);
  end

  logic anyWin, winOn;
  assign anyWin = |inWin;
  assign winOn  = |(inWin & shadowEn);

  always_comb begin
    hitInternal = 1'b1;
    toExternal  = 1'b0;
    writeDrop   = 1'b0;
    if (anyWin) begin
      if (!winOn) begin
        hitInternal = 1'b0;
        toExternal  = 1'b1;
      end else if (memWrite && wrProt) begin
        hitInternal = 1'b0;
        writeDrop   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgBlock.sv
module cfgBlock
  import cfgPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 256,
  parameter int MEM_AW = 20,
  parameter int NUM_WIN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioCs,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              extCacheEn,
  output logic              intCacheEn,
  output logic              waitUpd,
  input  logic [MEM_AW-1:0] memAddr,
  input  logic              memWrite,
  output logic              hitInternal,
  output logic              toExternal,
  output logic              writeDrop
);
  ioStrobes_t         stb;
  logic [NUM_WIN-1:0] shadowEn;
  logic               wrProt;

  cfgCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .ioCs(ioCs), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .stb(stb)
  );

  cfgData #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_WIN(NUM_WIN)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(ioWdata), .rdata(ioRdata),
    .extCacheEn(extCacheEn), .intCacheEn(intCacheEn), .waitUpd(waitUpd),
    .shadowEn(shadowEn), .wrProt(wrProt)
  );

  shadowDecode #(.MEM_AW(MEM_AW), .NUM_WIN(NUM_WIN)) uShadow (
    .memAddr(memAddr), .memWrite(memWrite), .shadowEn(shadowEn), .wrProt(wrProt),
    .hitInternal(hitInternal), .toExternal(toExternal), .writeDrop(writeDrop)
  );
endmodule

// File: rtl/cfgBlockChk.sv
module cfgBlockChk (
  input logic        clk,
  input logic        rstN,
  input logic        ioCs,
  input logic        ioWr,
  input logic        ioRd,
  input logic [15:0] ioAddr,
  input logic [7:0]  ioWdata,
  input logic [7:0]  ioRdata,
  input logic        waitUpd,
  input logic [19:0] memAddr,
  input logic        memWrite,
  input logic        hitInternal,
  input logic        toExternal,
  input logic        writeDrop
);
  logic [7:0] idxShadow;
  always_ff @(posedge clk) begin
    if (!rstN) idxShadow <= 8'h00;
    else if (ioCs && ioWr && ioAddr == 16'hF2) idxShadow <= ioWdata;
  end

  logic waitCause;
  assign waitCause = ioCs && ioWr && ioAddr == 16'hF3 &&
                     (idxShadow == 8'h01 || idxShadow == 8'h04 || idxShadow == 8'h1A);

  AST_WAIT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (waitUpd == $past(waitCause))) else $error("wait strobe");  // R11

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hitInternal, toExternal, writeDrop}) == 1) else $error("route");  // R8

  AST_LOW_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr < 20'hC0000) |-> hitInternal) else $error("low mem");  // R8

  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    writeDrop |-> memWrite) else $error("drop on read");  // R6

  AST_MASK_09: assert property (@(posedge clk) disable iff (!rstN)
    (ioCs && ioRd && ioAddr == 16'hF3 && idxShadow == 8'h09) |-> (ioRdata[7:2] == 6'h0))
    else $error("mask");  // R4

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(ioCs && ioRd) |-> (ioRdata == 8'h00)) else $error("idle read");  // R12
endmodule

bind cfgBlock cfgBlockChk chk (.*);

// File: tb/cfgBlock_test.sv
`timescale 1ns/1ps
module cfgBlock_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioCs = 1'b0, ioWr = 1'b0, ioRd = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWdata = '0;
  logic [7:0]  ioRdata;
  logic        extCacheEn, intCacheEn, waitUpd;
  logic [19:0] memAddr = '0;
  logic        memWrite = 1'b0;
  logic        hitInternal, toExternal, writeDrop;

  int nTests = 0, nFail = 0;
  logic [7:0] model [256];
  logic [7:0] mIdx;

  always #2.5 clk = ~clk;

  cfgBlock uut (.*);

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expMask(input logic [7:0] i);
    case (i)
      8'h01: return 8'hD3;  8'h02: return 8'h7F;  8'h03: return 8'h1F;
      8'h05: return 8'hF3;  8'h06: return 8'h1F;  8'h07: return 8'h1F;
      8'h08: return 8'h0F;  8'h09: return 8'h03;  8'h12: return 8'hBB;
      8'h18: return 8'h77;  8'h19: return 8'hFB;  8'h1B: return 8'hEF;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [2:0] expRoute(input logic [19:0] a, input logic wr, input logic [7:0] r);
    int w;
    if (a < 20'hC0000) return 3'b100;
    if (a < 20'hC8000) w = 0;
    else if (a < 20'hD0000) w = 1;
    else if (a < 20'hE0000) w = 2;
    else if (a < 20'hF0000) w = 3;
    else w = 4;
    if (!r[w]) return 3'b010;
    if (wr && r[5]) return 3'b001;
    return 3'b100;
  endfunction

  task automatic ioWrite(input logic cs, input logic [15:0] a, input logic [7:0] d, output logic pulse);
    @(negedge clk);
    ioCs = cs; ioWr = 1'b1; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioCs = 1'b0; ioWr = 1'b0;
    pulse = waitUpd;
    if (cs && a == 16'hF2) mIdx = d;
    if (cs && a == 16'hF3) model[mIdx] = d & expMask(mIdx);
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioCs = 1'b1; ioRd = 1'b1; ioAddr = a;
    #1 d = ioRdata;
    ioCs = 1'b0; ioRd = 1'b0;
  endtask

  task automatic probe(input logic [19:0] a, input logic wr, input string tag);
    logic [2:0] e;
    memAddr = a; memWrite = wr;
    #1 e = expRoute(a, wr, model[8'h02]);
    check({hitInternal, toExternal, writeDrop} == e, tag, {hitInternal, toExternal, writeDrop}, e);
  endtask

  task automatic wrReg(input logic [7:0] i, input logic [7:0] d, output logic pulse);
    logic p;
    ioWrite(1'b1, 16'hF2, i, p);
    ioWrite(1'b1, 16'hF3, d, pulse);
  endtask

  logic [7:0] rd;
  logic pulse;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    mIdx = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    ioRead(16'hF2, rd); check(rd == 8'h00, "R1 index reset", rd, 0);
    ioRead(16'hF3, rd); check(rd == 8'h00, "R1 reg reset", rd, 0);
    check(extCacheEn == 1'b0, "R1 extCache reset", extCacheEn, 0);
    check(intCacheEn == 1'b1, "R1 intCache reset", intCacheEn, 1);
    probe(20'hC0000, 1'b0, "R1 shadow off C0000");
    probe(20'hFFFFF, 1'b1, "R1 shadow off FFFFF");

    ioWrite(1'b1, 16'hF2, 8'h5A, pulse);
    ioRead(16'hF2, rd); check(rd == 8'h5A, "R2 index readback", rd, 8'h5A);

    foreach (model[i]) if (i < 32) begin
      wrReg(8'(i), 8'hFF, pulse);
      ioRead(16'hF3, rd);
      check(rd == expMask(8'(i)), "R4 mask", rd, expMask(8'(i)));
    end

    wrReg(8'h04, 8'h01, pulse);
    check(pulse == 1'b1, "R11 pulse on 04", pulse, 1);
    @(negedge clk); check(waitUpd == 1'b0, "R11 single cycle", waitUpd, 0);
    check(extCacheEn == 1'b1, "R9 extCache on", extCacheEn, 1);
    wrReg(8'h1A, 8'h40, pulse);
    check(pulse == 1'b1, "R11 pulse on 1A", pulse, 1);
    check(intCacheEn == 1'b0, "R10 intCache off", intCacheEn, 0);
    wrReg(8'h03, 8'h01, pulse);
    check(pulse == 1'b0, "R11 no pulse on 03", pulse, 0);

    wrReg(8'h02, 8'h00, pulse);
    ioWrite(1'b0, 16'hF3, 8'h1F, pulse);
    ioWrite(1'b1, 16'hF4, 8'h1F, pulse);
    ioWrite(1'b0, 16'hF2, 8'h77, pulse);
    ioRead(16'hF2, rd); check(rd == 8'h02, "R12 index untouched", rd, 2);
    ioRead(16'hF3, rd); check(rd == 8'h00, "R12 reg untouched", rd, 0);
    ioRead(16'hF4, rd); check(rd == 8'h00, "R12 other port reads 0", rd, 0);

    wrReg(8'h02, 8'h15, pulse);
    probe(20'hBFFFF, 1'b1, "R8 below window");
    probe(20'hC0000, 1'b0, "R5 win0 first read");
    probe(20'hC7FFF, 1'b1, "R5 win0 last write");
    probe(20'hC8000, 1'b0, "R7 win1 disabled");
    probe(20'hCFFFF, 1'b1, "R7 win1 last");
    probe(20'hD0000, 1'b0, "R5 win2 first");
    probe(20'hEFFFF, 1'b1, "R7 win3 last");
    probe(20'hF0000, 1'b1, "R5 win4 write");
    wrReg(8'h02, 8'h3F, pulse);
    probe(20'hE8000, 1'b1, "R6 protected write drop");
    probe(20'hE8000, 1'b0, "R6 protected read internal");
    probe(20'h12345, 1'b1, "R8 low mem unaffected");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] i, d, e;
      logic expP;
      i = ($urandom % 2) ? 8'($urandom % 32) : 8'($urandom);
      d = 8'($urandom);
      expP = (i == 8'h01) || (i == 8'h04) || (i == 8'h1A);
      wrReg(i, d, pulse);
      check(pulse == expP, "R11 random strobe", pulse, expP);
      e = model[i];
      ioRead(16'hF3, rd); check(rd == e, "R3 random readback", rd, e);
      check(extCacheEn == model[8'h04][0], "R9 random", extCacheEn, model[8'h04][0]);
      check(intCacheEn == ~model[8'h1A][6], "R10 random", intCacheEn, ~model[8'h1A][6]);
      if (n % 4 == 0) begin
        wrReg(8'h02, 8'($urandom), pulse);
      end
      for (int k = 0; k < 3; k++) probe(20'($urandom), 1'($urandom), "R5 R6 R7 random route");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule